// File: doc/BRIEF.md
# Audio Serial Port Register Block

This block is the software-visible control and status layer of a stereo audio serial port. A processor reaches it over a simple 32-bit bus that is addressed in words. Through the bus it starts and stops the receiver, the transmitter and the bit-clock generator, moves samples through one receive holding word and one transmit holding word, and services error flags. The serializer sits next to this block and connects through two hooks. A receive hook delivers each captured sample with its slot number. A transmit hook requests the next sample for a slot.

Each error is recorded twice. A summary flag records that an overrun or underrun happened. A per-slot sticky flag records which of up to eight time slots was affected. Software clears these flags through a write-one-to-clear alias of the status word. It can also force them through a write-one-to-set alias, which is useful for testing the interrupt path. The interrupt mask is changed with separate set and clear strobes, so a write to one mask bit leaves the others untouched. The block drives a single level-sensitive interrupt.

Top module: `audio_port_regs`

## Requirements
- R1: After reset, these read as zero: status (word 2), mode (word 1), mask (word 7) and the command word (word 0). The receiver, transmitter and clock enables and the interrupt are all low. Word 10 returns the VERSION parameter.
- R2: Word 0 is a write-only command word. Bit 0 enables the receiver and bit 1 disables it. Bit 2 enables the clock and bit 3 disables it. Bit 4 enables the transmitter and bit 5 disables it. Zero bits leave the state unchanged. When one write carries both the enable and the disable for the same unit, that unit ends up disabled.
- R3: A command write with bit 7 set clears mode, mask, every status flag and every enable in that one write. Reset takes priority over any enable bit written in the same word.
- R4: The mode word at word 1 stores all 32 written bits and reads them back unchanged.
- R5: While the receiver is enabled, an incoming sample sets status bit 1. A read of word 8 returns that sample and clears bit 1. While the receiver is disabled, incoming samples leave status unchanged.
- R6: A sample that arrives while bit 1 is still set raises status bit 2 and per-slot bit 8+slot. The new sample replaces the held one. Both flags stay set until they are cleared.
- R7: Status bit 0 mirrors the receiver enable and status bit 4 mirrors the transmitter enable. Status bit 5 is set when the transmitter is enabled and the transmit holding word is empty. A write to word 9 fills that word. A request from the transmit hook presents the held sample on txData and empties the word.
- R8: A request that arrives while the transmit holding word is empty raises status bit 6 and per-slot bit 20+slot. txData is zero while the word is empty.
- R9: Writing ones to word 3 clears the matching sticky bits: 2, 6, 15:8 and 27:20. Bits written as zero are left unchanged.
- R10: Writing ones to word 4 sets the matching sticky bits (2, 6, 15:8, 27:20).
- R11: Writing ones to word 5 sets mask bits and writing ones to word 6 clears them. Word 7 reads the mask. Only bits 1, 2, 5 and 6 can be set.
- R12: irq is high exactly when at least one of status bits 1, 2, 5 and 6 is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Bus access this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word index of the register |
| cpuWdata | input | 32 | Write data |
| cpuRdata | output | 32 | Read data, valid in the access cycle |
| rxValid | input | 1 | Receive hook: a sample is delivered |
| rxData | input | DATA_W | Receive hook: sample value |
| rxSlot | input | SLOT_W | Receive hook: slot of the sample |
| txReq | input | 1 | Transmit hook: next sample requested |
| txSlot | input | SLOT_W | Transmit hook: slot of the request |
| txData | output | DATA_W | Held transmit sample, zero when empty |
| rxEnable | output | 1 | Receiver enabled |
| txEnable | output | 1 | Transmitter enabled |
| clkEnable | output | 1 | Clock generator enabled |
| irq | output | 1 | Level interrupt |

## Verification
Several rules are checked by embedded properties on every cycle. Software reset must leave every enable and the mask at zero. A disable bit must win over its paired enable. Reading the receive word must clear receive-ready. A fill of the transmit word must mark it full. A raised interrupt always needs a nonzero mask. Other behaviours involve exact bit positions and the ordering of events, so only the directed scenarios can show them. These include where the per-slot flags land, that a second sample overwrites the first, that the clear alias touches only the bits written as one, that txData is zero on underrun, and that mask bits outside 1, 2, 5 and 6 are dropped.

// File: rtl/audio_port_regs_pkg.sv
package audio_port_regs_pkg;
  localparam int BUS_W = 32;

  // word indices on the register bus
  localparam logic [3:0] IDX_CMD  = 4'd0;
  localparam logic [3:0] IDX_MODE = 4'd1;
  localparam logic [3:0] IDX_STAT = 4'd2;
  localparam logic [3:0] IDX_CLR  = 4'd3;
  localparam logic [3:0] IDX_SET  = 4'd4;
  localparam logic [3:0] IDX_IEN  = 4'd5;
  localparam logic [3:0] IDX_IDIS = 4'd6;
  localparam logic [3:0] IDX_MASK = 4'd7;
  localparam logic [3:0] IDX_RHR  = 4'd8;
  localparam logic [3:0] IDX_THR  = 4'd9;
  localparam logic [3:0] IDX_VER  = 4'd10;

  // status bits that may raise the interrupt
  localparam logic [BUS_W-1:0] IRQ_BITS = 32'h0000_0066;

  typedef struct packed {
    logic             cmdWr;
    logic             modeWr;
    logic             clrWr;
    logic             setWr;
    logic             ienWr;
    logic             idisWr;
    logic             thrWr;
    logic             rhrRd;
    logic [BUS_W-1:0] wdata;
  } regStrobes_t;

  typedef struct packed {
    logic [BUS_W-1:0] status;
    logic [BUS_W-1:0] mode;
    logic [BUS_W-1:0] mask;
    logic [BUS_W-1:0] rhr;
  } regView_t;
endpackage

// File: rtl/audio_port_regs_ctrl.sv
module audio_port_regs_ctrl
  import audio_port_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [31:0] VERSION = 32'h0001_0300
) (
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [BUS_W-1:0]  cpuWdata,
  input  regView_t          view,
  output regStrobes_t       strobes,
  output logic [BUS_W-1:0]  cpuRdata
);
  localparam int IDX_W = 4;

  logic [IDX_W-1:0] idx;
  logic             inRange;
  logic             wrAcc;
  logic             rdAcc;

  generate
    if (ADDR_W > IDX_W) begin : g_wide
      assign inRange = (cpuAddr[ADDR_W-1:IDX_W] == '0);
      assign idx     = cpuAddr[IDX_W-1:0];
    end else begin : g_narrow
      assign inRange = 1'b1;
      assign idx     = IDX_W'(cpuAddr);
    end
  endgenerate

  assign wrAcc = cpuValid &&  cpuWrite && inRange;
  assign rdAcc = cpuValid && !cpuWrite && inRange;

  always_comb begin
    strobes        = '0;
    strobes.wdata  = cpuWdata;
    strobes.cmdWr  = wrAcc && (idx == IDX_CMD);
    strobes.modeWr = wrAcc && (idx == IDX_MODE);
    strobes.clrWr  = wrAcc && (idx == IDX_CLR);
    strobes.setWr  = wrAcc && (idx == IDX_SET);
    strobes.ienWr  = wrAcc && (idx == IDX_IEN);
    strobes.idisWr = wrAcc && (idx == IDX_IDIS);
    strobes.thrWr  = wrAcc && (idx == IDX_THR);
    strobes.rhrRd  = rdAcc && (idx == IDX_RHR);
  end

  always_comb begin
    cpuRdata = '0;
    if (rdAcc) begin
      unique case (idx)
        IDX_MODE: cpuRdata = view.mode;
        IDX_STAT: cpuRdata = view.status;
        IDX_MASK: cpuRdata = view.mask;
        IDX_RHR:  cpuRdata = view.rhr;
        IDX_VER:  cpuRdata = VERSION;
        default:  cpuRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/audio_port_regs_dp.sv
module audio_port_regs_dp
  import audio_port_regs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [SLOT_W-1:0] rxSlot,
  input  logic              txReq,
  input  logic [SLOT_W-1:0] txSlot,
  output logic [DATA_W-1:0] txData,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              clkEnable,
  output logic              irq,
  output regView_t          view
);
  localparam int RX_SLOT_LSB = 8;
  localparam int TX_SLOT_LSB = 20;

  logic              rxEnQ, txEnQ, clkEnQ;
  logic [BUS_W-1:0]  modeQ, maskQ;
  logic              rxRdyQ, rxOvrQ, txEmptyQ, txUrQ;
  logic [NUM_SLOTS-1:0] rxSlotOvrQ, txSlotUrQ;
  logic [DATA_W-1:0] rhrQ, thrQ;
  logic [BUS_W-1:0]  statusW;
  logic [BUS_W-1:0]  wd;

  logic swrst, rxTake, txTake, overrunEv, underrunEv;

  assign wd         = strobes.wdata;
  assign swrst      = strobes.cmdWr && wd[7];
  assign rxTake     = rxValid && rxEnQ;
  assign txTake     = txReq && txEnQ;
  assign overrunEv  = rxTake && rxRdyQ && !strobes.rhrRd;
  assign underrunEv = txTake && txEmptyQ;

  // paired enable/disable strobes, disable dominant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnQ  <= 1'b0;
      txEnQ  <= 1'b0;
      clkEnQ <= 1'b0;
    end else if (swrst) begin
      rxEnQ  <= 1'b0;
      txEnQ  <= 1'b0;
      clkEnQ <= 1'b0;
    end else if (strobes.cmdWr) begin
      rxEnQ  <= wd[1] ? 1'b0 : (wd[0] ? 1'b1 : rxEnQ);
      clkEnQ <= wd[3] ? 1'b0 : (wd[2] ? 1'b1 : clkEnQ);
      txEnQ  <= wd[5] ? 1'b0 : (wd[4] ? 1'b1 : txEnQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      maskQ <= '0;
    end else if (swrst) begin
      modeQ <= '0;
      maskQ <= '0;
    end else begin
      if (strobes.modeWr) modeQ <= wd;
      maskQ <= (maskQ | (strobes.ienWr ? wd : '0))
               & ~(strobes.idisWr ? wd : '0) & IRQ_BITS;
    end
  end

  // receive holding word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxRdyQ <= 1'b0;
      rhrQ   <= '0;
    end else if (swrst) begin
      rxRdyQ <= 1'b0;
      rhrQ   <= '0;
    end else if (rxTake) begin
      rxRdyQ <= 1'b1;
      rhrQ   <= rxData;
    end else if (strobes.rhrRd) begin
      rxRdyQ <= 1'b0;
    end
  end

  // transmit holding word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmptyQ <= 1'b1;
      thrQ     <= '0;
    end else if (swrst) begin
      txEmptyQ <= 1'b1;
      thrQ     <= '0;
    end else if (strobes.thrWr) begin
      txEmptyQ <= 1'b0;
      thrQ     <= wd[DATA_W-1:0];
    end else if (txTake) begin
      txEmptyQ <= 1'b1;
    end
  end

  assign txData = txEmptyQ ? '0 : thrQ;

  // summary sticky flags: event and set alias beat the clear alias
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOvrQ <= 1'b0;
      txUrQ  <= 1'b0;
    end else if (swrst) begin
      rxOvrQ <= 1'b0;
      txUrQ  <= 1'b0;
    end else begin
      if (overrunEv || (strobes.setWr && wd[2]))       rxOvrQ <= 1'b1;
      else if (strobes.clrWr && wd[2])                 rxOvrQ <= 1'b0;
      if (underrunEv || (strobes.setWr && wd[6]))      txUrQ  <= 1'b1;
      else if (strobes.clrWr && wd[6])                 txUrQ  <= 1'b0;
    end
  end

  // per-slot sticky flags
  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic rxHit, txHit;
      assign rxHit = overrunEv  && (rxSlot == SLOT_W'(i));
      assign txHit = underrunEv && (txSlot == SLOT_W'(i));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rxSlotOvrQ[i] <= 1'b0;
          txSlotUrQ[i]  <= 1'b0;
        end else if (swrst) begin
          rxSlotOvrQ[i] <= 1'b0;
          txSlotUrQ[i]  <= 1'b0;
        end else begin
          if (rxHit || (strobes.setWr && wd[RX_SLOT_LSB+i]))
            rxSlotOvrQ[i] <= 1'b1;
          else if (strobes.clrWr && wd[RX_SLOT_LSB+i])
            rxSlotOvrQ[i] <= 1'b0;
          if (txHit || (strobes.setWr && wd[TX_SLOT_LSB+i]))
            txSlotUrQ[i] <= 1'b1;
          else if (strobes.clrWr && wd[TX_SLOT_LSB+i])
            txSlotUrQ[i] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    statusW = '0;
    statusW[0] = rxEnQ;
    statusW[1] = rxRdyQ;
    statusW[2] = rxOvrQ;
    statusW[4] = txEnQ;
    statusW[5] = txEnQ && txEmptyQ;
    statusW[6] = txUrQ;
    statusW[RX_SLOT_LSB +: NUM_SLOTS] = rxSlotOvrQ;
    statusW[TX_SLOT_LSB +: NUM_SLOTS] = txSlotUrQ;
  end

  assign irq       = |(statusW & maskQ & IRQ_BITS);
  assign rxEnable  = rxEnQ;
  assign txEnable  = txEnQ;
  assign clkEnable = clkEnQ;

  always_comb begin
    view        = '0;
    view.status = statusW;
    view.mode   = modeQ;
    view.mask   = maskQ;
    view.rhr    = BUS_W'(rhrQ);
  end

  // R3
  swrst_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(swrst) |-> (!rxEnQ && !txEnQ && !clkEnQ && maskQ == '0 && modeQ == '0));

  // R2
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.cmdWr && wd[1]) |-> !rxEnable);

  // R5
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.rhrRd && !rxTake) |-> !statusW[1]);

  // R7
  tx_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.thrWr && !swrst) |-> !txEmptyQ);

  // R12
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskQ != '0));
endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
  import audio_port_regs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter logic [31:0] VERSION = 32'h0001_0300,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [SLOT_W-1:0] rxSlot,
  input  logic              txReq,
  input  logic [SLOT_W-1:0] txSlot,
  output logic [DATA_W-1:0] txData,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              clkEnable,
  output logic              irq
);
  regStrobes_t strobes;
  regView_t    view;

  audio_port_regs_ctrl #(.ADDR_W(ADDR_W), .VERSION(VERSION)) ctrl (
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .view(view), .strobes(strobes), .cpuRdata(cpuRdata)
  );

  audio_port_regs_dp #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rxValid(rxValid), .rxData(rxData), .rxSlot(rxSlot),
    .txReq(txReq), .txSlot(txSlot), .txData(txData),
    .rxEnable(rxEnable), .txEnable(txEnable), .clkEnable(clkEnable),
    .irq(irq), .view(view)
  );
endmodule

// File: tb/audio_port_regs_test.sv
module audio_port_regs_test;
  localparam logic [31:0] VER = 32'h0001_0300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [3:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0, cpuRdata;
  logic        rxValid = 1'b0, txReq = 1'b0;
  logic [31:0] rxData = '0, txData;
  logic [2:0]  rxSlot = '0, txSlot = '0;
  logic        rxEnable, txEnable, clkEnable, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_port_regs #(.VERSION(VER)) uut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .rxValid(rxValid), .rxData(rxData), .rxSlot(rxSlot),
    .txReq(txReq), .txSlot(txSlot), .txData(txData),
    .rxEnable(rxEnable), .txEnable(txEnable), .clkEnable(clkEnable), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    cpuValid = 1; cpuWrite = 1; cpuAddr = a; cpuWdata = d;
    @(posedge clk); @(negedge clk);
    cpuValid = 0; cpuWrite = 0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [31:0] d);
    cpuValid = 1; cpuWrite = 0; cpuAddr = a;
    #1 d = cpuRdata;
    @(posedge clk); @(negedge clk);
    cpuValid = 0;
  endtask

  task automatic rxPush(logic [31:0] v, logic [2:0] s);
    rxValid = 1; rxData = v; rxSlot = s;
    @(posedge clk); @(negedge clk);
    rxValid = 0;
  endtask

  task automatic txPull(logic [2:0] s, output logic [31:0] d);
    txReq = 1; txSlot = s;
    #1 d = txData;
    @(posedge clk); @(negedge clk);
    txReq = 0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(4'd2, v);  check("R1 status", v, 0);
    busRead(4'd1, v);  check("R1 mode", v, 0);
    busRead(4'd7, v);  check("R1 mask", v, 0);
    busRead(4'd0, v);  check("R1 cmd reads zero", v, 0);
    busRead(4'd10, v); check("R1 version", v, VER);
    check("R1 enables+irq", {rxEnable, txEnable, clkEnable, irq}, 0);
  endtask

  task automatic testMode();
    logic [31:0] v;
    busWrite(4'd1, 32'hA5A5_1234);
    busRead(4'd1, v); check("R4 mode readback", v, 32'hA5A5_1234);
  endtask

  task automatic testCommand();
    logic [31:0] v;
    busWrite(4'd0, 32'h15);
    check("R2 all enabled", {rxEnable, txEnable, clkEnable}, 3'b111);
    busRead(4'd2, v); check("R7 status enables + tx ready", v, 32'h31);
    busWrite(4'd0, 32'h0C);
    check("R2 clk disable wins", {rxEnable, txEnable, clkEnable}, 3'b110);
    busWrite(4'd0, 32'h04);
    check("R2 clk re-enable", clkEnable, 1);
  endtask

  task automatic testReceive();
    logic [31:0] v;
    rxPush(32'hCAFE_0001, 3'd3);
    busRead(4'd2, v); check("R5 rx ready set", v, 32'h33);
    busRead(4'd8, v); check("R5 rhr value", v, 32'hCAFE_0001);
    busRead(4'd2, v); check("R5 rx ready cleared by read", v, 32'h31);
    rxPush(32'h1111_2222, 3'd2);
    rxPush(32'h3333_4444, 3'd5);
    busRead(4'd2, v); check("R6 overrun + slot5 flag", v, 32'h2037);
    busRead(4'd8, v); check("R6 newest sample kept", v, 32'h3333_4444);
  endtask

  task automatic testClear();
    logic [31:0] v;
    busWrite(4'd3, 32'h2000);
    busRead(4'd2, v); check("R9 slot flag only cleared", v, 32'h35);
    busWrite(4'd3, 32'h4);
    busRead(4'd2, v); check("R9 summary cleared", v, 32'h31);
  endtask

  task automatic testTransmit();
    logic [31:0] v;
    busWrite(4'd9, 32'h0000_1234);
    busRead(4'd2, v); check("R7 tx ready clears on fill", v, 32'h11);
    txPull(3'd0, v); check("R7 txData held sample", v, 32'h1234);
    busRead(4'd2, v); check("R7 tx ready after consume", v, 32'h31);
    txPull(3'd6, v); check("R8 txData zero on underrun", v, 0);
    busRead(4'd2, v); check("R8 underrun + slot6 flag", v, 32'h0400_0071);
  endtask

  task automatic testInterrupt();
    logic [31:0] v;
    #1 check("R12 irq low with empty mask", irq, 0);
    busWrite(4'd5, 32'h40);
    busRead(4'd7, v); check("R11 mask set", v, 32'h40);
    check("R12 irq from underrun", irq, 1);
    busWrite(4'd5, 32'hFFFF_FFFF);
    busRead(4'd7, v); check("R11 only 1,2,5,6 maskable", v, 32'h66);
    busWrite(4'd6, 32'h40);
    busRead(4'd7, v); check("R11 mask clear strobe", v, 32'h26);
    check("R12 irq from tx ready", irq, 1);
    busWrite(4'd6, 32'h66);
    check("R12 irq low after mask off", irq, 0);
    busWrite(4'd3, 32'h0FF0_FF44);
  endtask

  task automatic testSetAlias();
    logic [31:0] v;
    busWrite(4'd4, 32'h0010_0104);
    busRead(4'd2, v); check("R10 set alias", v, 32'h0010_0135);
    busWrite(4'd3, 32'h0FF0_FF44);
    busRead(4'd2, v); check("R9 clear all sticky", v, 32'h31);
  endtask

  task automatic testSoftReset();
    logic [31:0] v;
    busWrite(4'd1, 32'hDEAD_BEEF);
    busWrite(4'd5, 32'h66);
    busWrite(4'd4, 32'h44);
    busWrite(4'd0, 32'h95);
    check("R3 enables cleared", {rxEnable, txEnable, clkEnable}, 0);
    busRead(4'd1, v); check("R3 mode cleared", v, 0);
    busRead(4'd7, v); check("R3 mask cleared", v, 0);
    busRead(4'd2, v); check("R3 status cleared", v, 0);
    rxPush(32'h5555_AAAA, 3'd1);
    busRead(4'd2, v); check("R5 rx ignored while disabled", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testMode();
    testCommand();
    testReceive();
    testClear();
    testTransmit();
    testInterrupt();
    testSetAlias();
    testSoftReset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule